// File: doc/BRIEF.md
# Core-Side Store Buffer with Load Forwarding

This block sits between a processor core and its private data cache. Stores from the core are queued as soon as they arrive, so the core never waits while the cache is still gaining write permission for the target line. Queued stores go out on the cache write port oldest first. Each one leaves only when the cache shows, on its ready input, that it holds permission to write.

A core load first looks in the buffer, matching on the full word address. If one or more pending stores match, the load gets the value of the most recent one in the same cycle. If none match, the load is sent on to the cache in that same cycle. Until a store has been written into the cache, it can be seen only by this core's own loads. The core can raise a store fence. The fence holds back every later load and store until the buffer has emptied into the cache. Completion is then signalled on a done output.

Top module: `store_buffer`

## Requirements
- R1: A store is accepted at a clock edge where `st_valid` and `st_ready` are both high. `st_ready` does not depend on `cw_ready`. A store presented while `st_ready` is low is dropped and never reaches the cache.
- R2: While the buffer holds entries, `cw_valid` is high and `cw_addr`/`cw_data` show the oldest entry. That entry retires at an edge where `cw_ready` is high. Entries leave in the order they were accepted.
- R3: While `cw_valid` is high and `cw_ready` is low, the presented entry stays unchanged on the following cycle.
- R4: A store is never shown on the cache port in the cycle it is accepted. An empty buffer keeps `cw_valid` low.
- R5: In the same cycle as a load (`ld_valid`), `ld_hit` is high when a buffered entry has an equal word address. `ld_data` then carries the data of the youngest such entry. This includes the head entry even in the cycle it retires. Stores accepted at earlier edges are visible to the search. `ld_data` is zero when there is no hit.
- R6: A load that matches no entry raises `ld_cache_req` in the same cycle, with `ld_cache_addr` equal to `ld_addr`. `ld_hit` and `ld_cache_req` are never high together.
- R7: The buffer holds 8 entries by default. When it is full, `st_ready` is low. `st_ready` is high again in the cycle after an entry retires.
- R8: While `fence_req` is high, `st_ready` and `ld_ready` are low and no load hits or is sent to the cache.
- R9: With `fence_req` held high, `fence_done` rises in the cycle after the first cycle in which the buffer is empty. It stays high until the cycle after `fence_req` falls. It is never high while the buffer holds entries.
- R10: After reset the buffer is empty: `cw_valid` and `fence_done` are low and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| ld_valid | input | 1 | Core load request |
| ld_addr | input | AW | Load word address |
| ld_ready | output | 1 | Load may proceed (low during a fence) |
| ld_hit | output | 1 | Load served from the buffer |
| ld_data | output | DW | Forwarded store data |
| ld_cache_req | output | 1 | Load passed to the cache |
| ld_cache_addr | output | AW | Address of the passed load |
| cw_valid | output | 1 | Oldest entry offered to the cache |
| cw_addr | output | AW | Address of the oldest entry |
| cw_data | output | DW | Data of the oldest entry |
| cw_ready | input | 1 | Cache holds write permission; entry is taken |
| fence_req | input | 1 | Store fence request, held until done |
| fence_done | output | 1 | Buffer drained under the fence |

## Verification
All forwarding, miss and cache-port results are combinational over registered state. The bench drives its inputs just after an edge and reads these results in that same cycle, before the next edge. State changes such as retirement, a freed slot re-opening `st_ready`, or fence completion become visible one edge later. The bench counts the edges explicitly and checks on either side of each one. For example, under a fence over three entries with permission held, `fence_done` is checked to stay low for three edges and to be high after the fourth.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int SB_DEF_AW    = 32;
   localparam int SB_DEF_DW    = 32;
   localparam int SB_DEF_DEPTH = 8;

   typedef enum logic [1:0] {
      FNC_IDLE  = 2'd0,
      FNC_DRAIN = 2'd1,
      FNC_DONE  = 2'd2
   } sb_fence_e;
endpackage

// File: rtl/sb_ring.sv
module sb_ring #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [PW-1:0] head,
   output logic [CW-1:0] occ,
   output logic          full,
   output logic          empty,
   output logic [AW-1:0] slot_addr [DEPTH],
   output logic [DW-1:0] slot_data [DEPTH]
);
   logic [PW-1:0] tail;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && (tail == PW'(g))) begin
            slot_addr[g] <= push_addr;
            slot_data[g] <= push_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         occ <= occ + CW'(push) - CW'(pop);
      end
   end

   assign full  = (occ == CW'(DEPTH));
   assign empty = (occ == '0);
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic [PW-1:0] head,
   input  logic [CW-1:0] occ,
   input  logic [AW-1:0] slot_addr [DEPTH],
   input  logic [DW-1:0] slot_data [DEPTH],
   input  logic [AW-1:0] probe_addr,
   output logic          hit,
   output logic [DW-1:0] hit_data
);
   logic [DEPTH-1:0] eq;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      logic [PW-1:0] age;
      assign age   = PW'(g) - head;
      assign eq[g] = ({1'b0, age} < occ) && (slot_addr[g] == probe_addr);
   end

   // walk from oldest to youngest so the youngest match wins
   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         logic [PW-1:0] idx;
         idx = head + PW'(i);
         if (eq[idx]) begin
            hit      = 1'b1;
            hit_data = slot_data[idx];
         end
      end
   end
endmodule

// File: rtl/sb_fence.sv
module sb_fence
   import sb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic empty,
   output logic done
);
   sb_fence_e st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         FNC_IDLE:  if (req) st_nx = empty ? FNC_DONE : FNC_DRAIN;
         FNC_DRAIN: if (!req) st_nx = FNC_IDLE;
                    else if (empty) st_nx = FNC_DONE;
         FNC_DONE:  if (!req) st_nx = FNC_IDLE;
         default:   st_nx = FNC_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= FNC_IDLE;
      else        st <= st_nx;
   end

   assign done = (st == FNC_DONE);
endmodule

// File: rtl/store_buffer.sv
module store_buffer
   import sb_pkg::*;
#(
   parameter int AW    = SB_DEF_AW,
   parameter int DW    = SB_DEF_DW,
   parameter int DEPTH = SB_DEF_DEPTH,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   output logic          st_ready,
   input  logic          ld_valid,
   input  logic [AW-1:0] ld_addr,
   output logic          ld_ready,
   output logic          ld_hit,
   output logic [DW-1:0] ld_data,
   output logic          ld_cache_req,
   output logic [AW-1:0] ld_cache_addr,
   output logic          cw_valid,
   output logic [AW-1:0] cw_addr,
   output logic [DW-1:0] cw_data,
   input  logic          cw_ready,
   input  logic          fence_req,
   output logic          fence_done
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("store_buffer: DEPTH must be a power of two, at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("store_buffer: AW and DW must be positive");
   end

   logic          push, pop, full, empty, fwd_hit, ld_go;
   logic [PW-1:0] head;
   logic [CW-1:0] occ;
   logic [AW-1:0] slot_addr [DEPTH];
   logic [DW-1:0] slot_data [DEPTH];
   logic [DW-1:0] fwd_data;

   assign st_ready = !full && !fence_req;
   assign push     = st_valid && st_ready;
   assign pop      = !empty && cw_ready;

   sb_ring #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .head      (head),
      .occ       (occ),
      .full      (full),
      .empty     (empty),
      .slot_addr (slot_addr),
      .slot_data (slot_data)
   );

   sb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
      .head       (head),
      .occ        (occ),
      .slot_addr  (slot_addr),
      .slot_data  (slot_data),
      .probe_addr (ld_addr),
      .hit        (fwd_hit),
      .hit_data   (fwd_data)
   );

   sb_fence u_fence (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (fence_req),
      .empty (empty),
      .done  (fence_done)
   );

   assign cw_valid      = !empty;
   assign cw_addr       = slot_addr[head];
   assign cw_data       = slot_data[head];

   assign ld_ready      = !fence_req;
   assign ld_go         = ld_valid && ld_ready;
   assign ld_hit        = ld_go && fwd_hit;
   assign ld_data       = ld_hit ? fwd_data : '0;
   assign ld_cache_req  = ld_go && !fwd_hit;
   assign ld_cache_addr = ld_addr;
endmodule

// File: rtl/store_buffer_chk.sv
module store_buffer_chk #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_valid,
   input logic          st_ready,
   input logic          ld_ready,
   input logic          ld_hit,
   input logic          ld_cache_req,
   input logic          cw_valid,
   input logic [AW-1:0] cw_addr,
   input logic [DW-1:0] cw_data,
   input logic          cw_ready,
   input logic          fence_req,
   input logic          fence_done,
   input logic [CW-1:0] occ
);
   p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_data));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CW'(DEPTH)) |-> !st_ready);

   p_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) && !(st_valid && st_ready) |=> !cw_valid);

   p_fence_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fence_req |-> !st_ready && !ld_ready && !ld_hit && !ld_cache_req);

   p_done_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |-> !cw_valid);

   p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fence_done) |-> $past(fence_req));

   p_hit_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_hit && ld_cache_req));
endmodule

bind store_buffer store_buffer_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st_valid     (st_valid),
   .st_ready     (st_ready),
   .ld_ready     (ld_ready),
   .ld_hit       (ld_hit),
   .ld_cache_req (ld_cache_req),
   .cw_valid     (cw_valid),
   .cw_addr      (cw_addr),
   .cw_data      (cw_data),
   .cw_ready     (cw_ready),
   .fence_req    (fence_req),
   .fence_done   (fence_done),
   .occ          (occ)
);

// File: tb/store_buffer_tb.sv
`timescale 1ns/100ps
module store_buffer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0, ld_valid = 1'b0, cw_ready = 1'b0, fence_req = 1'b0;
   logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
   logic        st_ready, ld_ready, ld_hit, ld_cache_req, cw_valid, fence_done;
   logic [31:0] ld_data, ld_cache_addr, cw_addr, cw_data;
   int          checks = 0, errors = 0;
   bit          done_flag = 1'b0;

   always #2.5 clk = ~clk;

   store_buffer u_dut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready), .ld_hit(ld_hit),
      .ld_data(ld_data), .ld_cache_req(ld_cache_req), .ld_cache_addr(ld_cache_addr),
      .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_ready(cw_ready),
      .fence_req(fence_req), .fence_done(fence_done)
   );

   typedef struct packed {
      logic       sv; logic [7:0] sa; logic [7:0] sd;
      logic       lv; logic [7:0] la; logic       rdy;
      logic       eh; logic [7:0] ed;
      logic       ecv; logic [7:0] eca; logic [7:0] ecd;
   } vec_t;

   // per cycle: store, load, permission; expected hit/data and cache port
   localparam vec_t VEC [9] = '{
      '{1'b1, 8'd10, 8'd1, 1'b1, 8'd10, 1'b0, 1'b0, 8'd0, 1'b0, 8'd0,  8'd0},
      '{1'b1, 8'd20, 8'd2, 1'b1, 8'd10, 1'b0, 1'b1, 8'd1, 1'b1, 8'd10, 8'd1},
      '{1'b1, 8'd10, 8'd3, 1'b1, 8'd20, 1'b0, 1'b1, 8'd2, 1'b1, 8'd10, 8'd1},
      '{1'b0, 8'd0,  8'd0, 1'b1, 8'd10, 1'b0, 1'b1, 8'd3, 1'b1, 8'd10, 8'd1},
      '{1'b0, 8'd0,  8'd0, 1'b1, 8'd30, 1'b1, 1'b0, 8'd0, 1'b1, 8'd10, 8'd1},
      '{1'b0, 8'd0,  8'd0, 1'b1, 8'd10, 1'b1, 1'b1, 8'd3, 1'b1, 8'd20, 8'd2},
      '{1'b0, 8'd0,  8'd0, 1'b1, 8'd20, 1'b0, 1'b0, 8'd0, 1'b1, 8'd10, 8'd3},
      '{1'b0, 8'd0,  8'd0, 1'b1, 8'd10, 1'b1, 1'b1, 8'd3, 1'b1, 8'd10, 8'd3},
      '{1'b0, 8'd0,  8'd0, 1'b1, 8'd10, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0,  8'd0}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      // R10 reset state
      chk(cw_valid == 1'b0, "R10", "cw_valid", 32'(cw_valid), 0);
      chk(st_ready == 1'b1, "R10", "st_ready", 32'(st_ready), 1);
      chk(fence_done == 1'b0, "R10", "fence_done", 32'(fence_done), 0);
      next_cycle();

      // table: R1 R2 R4 R5 R6
      for (int i = 0; i < 9; i++) begin
         st_valid = VEC[i].sv; st_addr = 32'(VEC[i].sa); st_data = 32'(VEC[i].sd);
         ld_valid = VEC[i].lv; ld_addr = 32'(VEC[i].la); cw_ready = VEC[i].rdy;
         settle();
         chk(ld_hit == VEC[i].eh, "R5", "ld_hit", 32'(ld_hit), 32'(VEC[i].eh));
         if (VEC[i].eh)
            chk(ld_data == 32'(VEC[i].ed), "R5", "ld_data", ld_data, 32'(VEC[i].ed));
         chk(ld_cache_req == !VEC[i].eh, "R6", "ld_cache_req", 32'(ld_cache_req), 32'(!VEC[i].eh));
         if (!VEC[i].eh)
            chk(ld_cache_addr == ld_addr, "R6", "ld_cache_addr", ld_cache_addr, ld_addr);
         chk(cw_valid == VEC[i].ecv, "R4", "cw_valid", 32'(cw_valid), 32'(VEC[i].ecv));
         if (VEC[i].ecv) begin
            chk(cw_addr == 32'(VEC[i].eca), "R2", "cw_addr", cw_addr, 32'(VEC[i].eca));
            chk(cw_data == 32'(VEC[i].ecd), "R2", "cw_data", cw_data, 32'(VEC[i].ecd));
         end
         if (VEC[i].sv)
            chk(st_ready == 1'b1, "R1", "st_ready without permission", 32'(st_ready), 1);
         next_cycle();
      end
      st_valid = 0; ld_valid = 0; cw_ready = 0;

      // R7 fill to depth with no permission
      for (int i = 0; i < 8; i++) begin
         st_valid = 1; st_addr = 32'(100 + i); st_data = 32'(50 + i);
         settle();
         chk(st_ready == 1'b1, "R7", "st_ready while filling", 32'(st_ready), 1);
         next_cycle();
      end
      st_addr = 32'd200; st_data = 32'd99;
      for (int i = 0; i < 2; i++) begin
         settle();
         chk(st_ready == 1'b0, "R7", "st_ready when full", 32'(st_ready), 0);
         chk(cw_addr == 32'd100, "R3", "cw_addr held", cw_addr, 100);
         chk(cw_data == 32'd50, "R3", "cw_data held", cw_data, 50);
         next_cycle();
      end
      st_valid = 0; cw_ready = 1;
      settle();
      chk(st_ready == 1'b0, "R7", "st_ready before retire", 32'(st_ready), 0);
      next_cycle();
      cw_ready = 0;
      settle();
      chk(st_ready == 1'b1, "R7", "st_ready after retire", 32'(st_ready), 1);
      next_cycle();
      cw_ready = 1;
      for (int i = 1; i < 8; i++) begin
         settle();
         chk(cw_data == 32'(50 + i), "R2", "drain order", cw_data, 32'(50 + i));
         next_cycle();
      end
      settle();
      chk(cw_valid == 1'b0, "R1", "refused store not queued", 32'(cw_valid), 0);
      next_cycle();

      // R8 R9 fence over three entries
      cw_ready = 0;
      for (int i = 0; i < 3; i++) begin
         st_valid = 1; st_addr = 32'(400 + i); st_data = 32'(i);
         next_cycle();
      end
      st_valid = 1; st_addr = 32'd300; st_data = 32'd77;
      ld_valid = 1; ld_addr = 32'd400;
      fence_req = 1; cw_ready = 1;
      for (int i = 0; i < 4; i++) begin
         settle();
         chk(st_ready == 1'b0, "R8", "st_ready in fence", 32'(st_ready), 0);
         chk(ld_ready == 1'b0, "R8", "ld_ready in fence", 32'(ld_ready), 0);
         chk(!ld_hit && !ld_cache_req, "R8", "load blocked", 32'({ld_hit, ld_cache_req}), 0);
         chk(fence_done == 1'b0, "R9", "fence_done early", 32'(fence_done), 0);
         next_cycle();
      end
      settle();
      chk(fence_done == 1'b1, "R9", "fence_done after empty", 32'(fence_done), 1);
      next_cycle();
      fence_req = 0; st_valid = 0; ld_valid = 0;
      settle();
      chk(fence_done == 1'b1, "R9", "fence_done holds a cycle", 32'(fence_done), 1);
      chk(cw_valid == 1'b0, "R8", "store during fence dropped", 32'(cw_valid), 0);
      next_cycle();
      settle();
      chk(fence_done == 1'b0, "R9", "fence_done clears", 32'(fence_done), 0);
      next_cycle();

      // R9 fence on an empty buffer
      fence_req = 1;
      settle();
      chk(fence_done == 1'b0, "R9", "empty fence same cycle", 32'(fence_done), 0);
      next_cycle();
      settle();
      chk(fence_done == 1'b1, "R9", "empty fence next cycle", 32'(fence_done), 1);
      next_cycle();
      fence_req = 0;
      next_cycle();
      finish_run();
   end
endmodule